// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block sits on the CPU side of an interrupt path. The arbiter in front of it has already picked a request and checked it against the current mask. The sequencer takes that request only at an instruction-decode boundary. The instruction that was decoded in that cycle is cancelled, and the sequencer performs exception entry in its place. It saves the status register and then the return address onto the stack through a memory write port. It adjusts the stack pointer and raises the status register's interrupt mask to the accepted level. It then reads the handler address from a vector table through a memory read port and loads it straight into the program counter.

The saved return address is the address of the cancelled instruction, so that instruction runs again after the handler returns. The jump to the handler has no delay slot. From the cycle the request is taken until the new program counter is written, every decoded instruction is held suppressed. Register values (status register, stack pointer, vector base, return address, level and vector number) are captured in the acceptance cycle. Changes to those inputs later in the sequence do not affect it.

Top module: `irq_entry_seq`

## Requirements
- R1: When idle, a cycle with both `decode_valid` and `irq_req` high is an acceptance. In that same cycle `irq_ack` is high for exactly one cycle and `suppress` is high.
- R2: From acceptance until the cycle that writes the program counter, `irq_ack` stays low whatever `irq_req` and `decode_valid` do. A request with `decode_valid` low is never accepted.
- R3: The first memory write after acceptance stores the captured status register at address SP-4.
- R4: The second memory write stores the address of the cancelled instruction at SP-8. Each write holds its address and data until `mem_wr_ready` is high.
- R5: After both writes, `sp_we` writes SP-8 into the stack pointer.
- R6: After both writes, `sr_we` writes the captured status register with bits [7:4] replaced by the accepted 4-bit level and all other bits unchanged.
- R7: The vector read uses address VBR + 4 × vector number, a single 32-bit read held until `mem_rd_valid`.
- R8: `pc_we` fires once, in the cycle `mem_rd_valid` is high, with the read data. `suppress` is high in every cycle from acceptance to that write, so no delay-slot instruction issues. The block is idle in the next cycle.
- R9: All values used by the sequence are those present at acceptance. Later changes on the input ports have no effect.
- R10: After reset the block is idle, with no memory access and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| decode_valid | input | 1 | An instruction is decoded this cycle (entry boundary) |
| decode_pc | input | 32 | Address of the decoded instruction |
| irq_req | input | 1 | Accepted request from the arbiter |
| irq_level | input | 4 | Priority level of the request |
| irq_vector | input | 8 | Vector number of the request |
| irq_ack | output | 1 | One-cycle acknowledge to the arbiter |
| sr_cur | input | 32 | Current status register |
| sp_cur | input | 32 | Current stack pointer |
| vbr_cur | input | 32 | Vector table base address |
| suppress | output | 1 | Cancel the decoded instruction |
| busy | output | 1 | Entry sequence in progress |
| mem_wr_en | output | 1 | Stack write request |
| mem_wr_addr | output | 32 | Stack write address |
| mem_wr_data | output | 32 | Stack write data |
| mem_wr_ready | input | 1 | Write accepted this cycle |
| mem_rd_en | output | 1 | Vector read request |
| mem_rd_addr | output | 32 | Vector read address |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 32 | New status register value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | New stack pointer value |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | Handler address |

## Verification
The bench keeps `irq_req` and `decode_valid` high for a whole sequence. A design that does not lock out new requests would acknowledge a second time. It also changes every input port right after acceptance, which exposes a design that reads the stack pointer or status register live instead of capturing them. Wait states on both memory ports check that requests are held. A version that moves on early would log a missing or extra write, or a wrong address. Level 15 with vector 255 and level 0 on an all-ones status register expose a mask merge that is off by a bit or clears the wrong field. Any cycle of unsuppressed decode before the program counter write is reported as a delay-slot leak.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int W        = 32,
  parameter int LW       = 4,
  parameter int VW       = 8,
  parameter int MASK_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          decode_valid,
  input  logic [W-1:0]  decode_pc,
  input  logic          irq_req,
  input  logic [LW-1:0] irq_level,
  input  logic [VW-1:0] irq_vector,
  output logic          irq_ack,
  input  logic [W-1:0]  sr_cur,
  input  logic [W-1:0]  sp_cur,
  input  logic [W-1:0]  vbr_cur,
  output logic          suppress,
  output logic          busy,
  output logic          mem_wr_en,
  output logic [W-1:0]  mem_wr_addr,
  output logic [W-1:0]  mem_wr_data,
  input  logic          mem_wr_ready,
  output logic          mem_rd_en,
  output logic [W-1:0]  mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [W-1:0]  mem_rd_data,
  output logic          sr_we,
  output logic [W-1:0]  sr_wdata,
  output logic          sp_we,
  output logic [W-1:0]  sp_wdata,
  output logic          pc_we,
  output logic [W-1:0]  pc_wdata
);
  localparam int WORD = W / 8;
  localparam int VSH  = $clog2(WORD);
  localparam logic [W-1:0] MASK_BITS = W'((1 << LW) - 1) << MASK_LSB;

  typedef enum logic [2:0] {S_IDLE, S_PUSH_SR, S_PUSH_PC, S_MASK, S_VEC} st_t;

  st_t           st;
  logic [W-1:0]  sr_q, sp_q, pc_q, vbr_q;
  logic [LW-1:0] lvl_q;
  logic [VW-1:0] vec_q;
  logic          take;

  assign take     = (st == S_IDLE) && decode_valid && irq_req;
  assign irq_ack  = take;
  assign busy     = (st != S_IDLE);
  assign suppress = take || busy;

  assign mem_wr_en   = (st == S_PUSH_SR) || (st == S_PUSH_PC);
  assign mem_wr_addr = (st == S_PUSH_SR) ? sp_q - W'(WORD) : sp_q - W'(2 * WORD);
  assign mem_wr_data = (st == S_PUSH_SR) ? sr_q : pc_q;

  assign sr_we    = (st == S_MASK);
  assign sr_wdata = (sr_q & ~MASK_BITS) | (W'(lvl_q) << MASK_LSB);
  assign sp_we    = (st == S_MASK);
  assign sp_wdata = sp_q - W'(2 * WORD);

  assign mem_rd_en   = (st == S_VEC);
  assign mem_rd_addr = vbr_q + (W'(vec_q) << VSH);
  assign pc_we       = (st == S_VEC) && mem_rd_valid;
  assign pc_wdata    = mem_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sr_q  <= '0;
      sp_q  <= '0;
      pc_q  <= '0;
      vbr_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st    <= S_PUSH_SR;
          sr_q  <= sr_cur;
          sp_q  <= sp_cur;
          pc_q  <= decode_pc;
          vbr_q <= vbr_cur;
          lvl_q <= irq_level;
          vec_q <= irq_vector;
        end
        S_PUSH_SR: if (mem_wr_ready) st <= S_PUSH_PC;
        S_PUSH_PC: if (mem_wr_ready) st <= S_MASK;
        S_MASK:    st <= S_VEC;
        S_VEC:     if (mem_rd_valid) st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  assert_ack_starts_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> busy);
  assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_ack);
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_wr_ready) |=> (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
  assert_pc_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> !busy);
  assert_suppress_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> suppress);
  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en));
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        decode_valid = 0, irq_req = 0;
  logic [31:0] decode_pc = 0, sr_cur = 0, sp_cur = 0, vbr_cur = 0;
  logic [3:0]  irq_level = 0;
  logic [7:0]  irq_vector = 0;
  logic        irq_ack, suppress, busy, mem_wr_en, mem_rd_en, sr_we, sp_we, pc_we;
  logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr, sr_wdata, sp_wdata, pc_wdata;
  logic        mem_wr_ready, mem_rd_valid;
  logic [31:0] mem_rd_data;

  always #2 clk = ~clk;

  irq_entry_seq dut_i (.*);

  int wr_lat = 0, rd_lat = 0, wcnt = 0, rcnt = 0;
  assign mem_wr_ready = mem_wr_en && (wcnt >= wr_lat);
  assign mem_rd_valid = mem_rd_en && (rcnt >= rd_lat);
  assign mem_rd_data  = ~mem_rd_addr;

  logic [31:0] wa [0:7];
  logic [31:0] wd [0:7];
  logic [31:0] sr_got, sp_got, pc_got, rd_got;
  int nw = 0, ev = 0, w2_ev = 0, sr_ev = 0, n_sr = 0, n_sp = 0, n_pc = 0, n_ack = 0;
  int leaks = 0;
  bit in_seq = 0;
  int tests = 0, fails = 0;

  always @(posedge clk) begin
    wcnt <= (mem_wr_en && !mem_wr_ready) ? wcnt + 1 : 0;
    rcnt <= (mem_rd_en && !mem_rd_valid) ? rcnt + 1 : 0;
    if (irq_ack) n_ack <= n_ack + 1;
    if (in_seq && decode_valid && !suppress) leaks <= leaks + 1;
    if (mem_wr_en && mem_wr_ready) begin
      if (nw < 8) begin wa[nw] <= mem_wr_addr; wd[nw] <= mem_wr_data; end
      nw <= nw + 1; ev <= ev + 1;
      if (nw == 1) w2_ev <= ev;
    end
    if (sr_we) begin sr_got <= sr_wdata; n_sr <= n_sr + 1; sr_ev <= ev; end
    if (sp_we) begin sp_got <= sp_wdata; n_sp <= n_sp + 1; end
    if (pc_we) begin pc_got <= pc_wdata; rd_got <= mem_rd_addr; n_pc <= n_pc + 1; end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic t_reset;
    @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 wr_en", 32'(mem_wr_en), 0);
    chk("R10 rd_en", 32'(mem_rd_en), 0);
    chk("R10 writes", 32'(sr_we | sp_we | pc_we), 0);
    chk("R10 ack", 32'(irq_ack), 0);
  endtask

  task automatic t_no_decode;
    int a0 = n_ack;
    @(negedge clk); irq_req = 1; decode_valid = 0;
    repeat (5) @(negedge clk);
    chk("R2 no ack without decode", 32'(n_ack - a0), 0);
    chk("R2 stays idle", 32'(busy), 0);
    irq_req = 0;
  endtask

  task automatic t_entry(string nm, logic [31:0] pc, logic [31:0] sr, logic [31:0] sp,
                         logic [31:0] vbr, logic [3:0] lvl, logic [7:0] vec,
                         int wl, int rl, bit hold_req);
    int a0 = n_ack;
    logic [31:0] exp_sr;
    exp_sr = (sr & 32'hFFFF_FF0F) | ({28'h0, lvl} << 4);
    wr_lat = wl; rd_lat = rl;
    nw = 0; n_sr = 0; n_sp = 0; n_pc = 0; leaks = 0;
    @(negedge clk);
    decode_pc = pc; sr_cur = sr; sp_cur = sp; vbr_cur = vbr;
    irq_level = lvl; irq_vector = vec; irq_req = 1; decode_valid = 1;
    #1;
    chk({"R1 ack ", nm}, 32'(irq_ack), 1);
    chk({"R1 suppress ", nm}, 32'(suppress), 1);
    @(posedge clk); in_seq = 1;
    @(negedge clk);
    decode_pc = ~pc; sr_cur = ~sr; sp_cur = sp ^ 32'h0F00; vbr_cur = vbr + 32'h40;
    irq_level = ~lvl; irq_vector = ~vec;
    if (!hold_req) begin irq_req = 0; decode_valid = 0; end
    else decode_valid = 1;
    while (!pc_we) @(negedge clk);
    irq_req = 0; decode_valid = 0;
    @(posedge clk); in_seq = 0;
    @(negedge clk);
    chk({"R2 single ack ", nm}, 32'(n_ack - a0), 1);
    chk({"R3 write count ", nm}, 32'(nw), 2);
    chk({"R3 SR addr ", nm}, wa[0], sp - 4);
    chk({"R3 SR data ", nm}, wd[0], sr);
    chk({"R4 PC addr ", nm}, wa[1], sp - 8);
    chk({"R4 PC data ", nm}, wd[1], pc);
    chk({"R5 SP ", nm}, sp_got, sp - 8);
    chk({"R5 SP once ", nm}, 32'(n_sp), 1);
    chk({"R6 SR mask ", nm}, sr_got, exp_sr);
    chk({"R6 SR after pushes ", nm}, 32'(sr_ev > w2_ev), 1);
    chk({"R7 vector addr ", nm}, rd_got, vbr + ({24'h0, vec} << 2));
    chk({"R8 PC ", nm}, pc_got, ~(vbr + ({24'h0, vec} << 2)));
    chk({"R8 PC once ", nm}, 32'(n_pc), 1);
    chk({"R8 no delay slot ", nm}, 32'(leaks), 0);
    chk({"R8 idle after ", nm}, 32'(busy), 0);
    chk({"R9 captured (SR once) ", nm}, 32'(n_sr), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_no_decode();
    t_entry("basic", 32'h0000_1234, 32'h0000_00F0, 32'h0000_8000, 32'h0001_0000, 4'd5, 8'd12, 0, 0, 0);
    t_entry("waits", 32'hCAFE_0010, 32'h1234_5670, 32'h2000_0100, 32'h0000_0400, 4'd9, 8'd64, 3, 4, 0);
    t_entry("max", 32'h0000_0002, 32'hFFFF_FF0F, 32'h0000_0008, 32'hFFFF_0000, 4'd15, 8'd255, 1, 2, 0);
    t_entry("lvl0", 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 4'd0, 8'd0, 0, 1, 0);
    t_entry("held req", 32'h0000_5000, 32'h0000_0030, 32'h0000_9000, 32'h0000_2000, 4'd7, 8'd33, 2, 3, 1);
    t_entry("back2back", 32'h0000_5002, 32'h0000_0070, 32'h0000_8FF8, 32'h0000_2000, 4'd8, 8'd34, 0, 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule